// File: doc/BRIEF.md
# Predecoded Instruction Cache

This block sits between an instruction fetch stage and a word-wide memory. It is a direct-mapped store of 64 lines. Each line covers 32 consecutive word slots, which is 128 bytes of code. A line is tagged with its owner, the address divided by 128. Slots do not hold raw words. They hold a compact decoded record: an operation code, three register fields and a 32-bit immediate. An execution stage can use such a record without decoding it again.

Lines are never refilled as a whole. When a line is allocated, every one of its slots becomes a placeholder. The first lookup that lands on a placeholder does four things:
- It issues a single word read to memory at owner × 128 + slot × 4.
- It decodes the returned word.
- It stores the record in that slot.
- It presents the record at the output in the same step.

Later lookups of that slot are answered directly from the stored record. If the memory reports a fault, the slot stays a placeholder and an access-fault pulse carries the fetch address. A flush input drops every line. It is used after code has been modified.

Top module: `pdc_cache`

## Requirements
- R1: After reset no line is valid, `ready` is 1, and `mem_req`, `out_valid` and `out_fault` are 0.
- R2: Address decomposition:
  - The line index is `req_pc[12:7]` and the slot index is `req_pc[6:2]`.
  - A line hits when it is valid and its stored owner equals `req_pc[31:7]`.
  - `req_pc[1:0]` are ignored.
- R3: A request accepted (`req_valid` while `ready`) on a valid line whose slot is already decoded gives `out_valid`=1 and the stored record in the following cycle, with no memory read (`mem_req` stays 0).
- R4: A request that reaches a placeholder drives `mem_req`=1 from the following cycle. `mem_addr` equals owner × 128 + slot × 4, and both are held until `mem_rvalid`.
- R5: `mem_rvalid` with `mem_fault`=0 during a fetch has three effects:
  - The next cycle shows `out_valid`=1 with the record decoded from `mem_rdata`.
  - `mem_req` drops.
  - The record is kept, so a repeated request to that slot hits as in R3.
- R6: A request to an invalid line, or to a line owned by another address, makes the requester the owner and turns all 32 of its slots into placeholders in one step. Slots decoded for the previous owner are fetched again when that owner returns.
- R7: `mem_rvalid` with `mem_fault`=1 during a fetch has three effects:
  - The next cycle shows `out_fault`=1 and `out_valid`=0.
  - `fault_addr` equals the fetch address.
  - The slot stays a placeholder, so a repeated request fetches again.
- R8: `flush`=1 invalidates all lines at the clock edge. During a `flush` cycle `ready` is 0 and a request is not accepted. Afterwards every slot is fetched again.
- R9: Register fields and immediates for recognised words:
  - `out_rd`=w[11:7], `out_rs1`=w[19:15], `out_rs2`=w[24:20].
  - I-format imm: sign-extended w[31:20]. S-format imm: sign-extended {w[31:25],w[11:7]}.
  - B-format imm: sign-extended {w[31],w[7],w[30:25],w[11:8],0}. J-format imm: sign-extended {w[31],w[19:12],w[20],w[30:21],0}.
  - U-format imm: {w[31:12],12'b0}.
  - Shift-immediate imm: zero-extended w[24:20].
  - Register-register operations, environment call and breakpoint: imm 0.
- R10: Operation codes are selected by w[6:0], funct3 = w[14:12] and funct7 = w[31:25]:
  - 0110111 → 1 (U-format).
  - 0010111 → 2 (U-format).
  - 1101111 → 3 (J-format).
  - 1100111 with funct3 0 → 4 (I-format).
  - 1100011: funct3 0,1,4,5,6,7 → 5..10 (B-format).
  - 0000011: funct3 0,1,2,4,5 → 11..15 (I-format).
  - 0100011: funct3 0,1,2 → 16..18 (S-format).
  - 0010011 (I-format):
    - funct3 0,2,3,4,6,7 → 19..24.
    - funct3 1 with funct7 0 → 25 (shift).
    - funct3 5 with funct7 0 → 26 (shift); funct3 5 with funct7 0x20 → 27 (shift).
  - 0110011 with funct7 0: funct3 0..7 → 28,30,31,32,33,34,36,37.
  - 0110011 with funct7 0x20: funct3 0 → 29, funct3 5 → 35.
  - 0001111 with funct3 0 → 38 (I-format).
  - Exactly 0x00000073 → 39; exactly 0x00100073 → 40.
- R11: Every other word decodes to operation code 0 (illegal), with all three register fields 0 and `out_imm` holding the raw 32-bit word.
- R12: While a fetch is outstanding, `ready` is 0 and any `req_valid` is ignored. No second fetch and no output follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate every line |
| req_valid | input | 1 | Lookup request |
| req_pc | input | 32 | Lookup address |
| ready | output | 1 | A request is accepted this cycle |
| mem_req | output | 1 | Word read outstanding |
| mem_addr | output | 32 | Word read address |
| mem_rvalid | input | 1 | Read answer present |
| mem_rdata | input | 32 | Read word |
| mem_fault | input | 1 | Read answer is a fault |
| out_valid | output | 1 | Decoded record valid (one cycle) |
| out_op | output | 7 | Operation code |
| out_rd | output | 5 | Destination register field |
| out_rs1 | output | 5 | First source register field |
| out_rs2 | output | 5 | Second source register field |
| out_imm | output | 32 | Immediate, or raw word when illegal |
| out_fault | output | 1 | Instruction access fault pulse |
| fault_addr | output | 32 | Address of the faulting fetch |

## Verification
The properties assume a well-behaved memory:
- It answers only while `mem_req` is high.
- It gives exactly one `mem_rvalid` pulse per fetch.
- `mem_rdata` and `mem_fault` are meaningful in that cycle.

The stimulus respects this. The memory model waits a random 0 to 3 cycles after `mem_req` rises, then pulses `mem_rvalid` once. Requests are presented only when `ready` is high, apart from deliberate stray requests during a pending fetch and during `flush`, which must be ignored. Instruction words are a pure function of their address, so a refetched slot always yields the same record. A few directed addresses substitute chosen words for decode corner cases.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef struct packed {
        logic [6:0]  op;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [31:0] imm;
    } rec_t;

    typedef enum logic [2:0] {
        IMM_ZERO, IMM_I, IMM_SH, IMM_S, IMM_B, IMM_U, IMM_J
    } imm_sel_e;

    localparam logic [6:0] MAJ_LUI    = 7'b0110111;
    localparam logic [6:0] MAJ_AUIPC  = 7'b0010111;
    localparam logic [6:0] MAJ_JAL    = 7'b1101111;
    localparam logic [6:0] MAJ_JALR   = 7'b1100111;
    localparam logic [6:0] MAJ_BRANCH = 7'b1100011;
    localparam logic [6:0] MAJ_LOAD   = 7'b0000011;
    localparam logic [6:0] MAJ_STORE  = 7'b0100011;
    localparam logic [6:0] MAJ_OPIMM  = 7'b0010011;
    localparam logic [6:0] MAJ_OP     = 7'b0110011;
    localparam logic [6:0] MAJ_FENCE  = 7'b0001111;
    localparam logic [6:0] MAJ_SYSTEM = 7'b1110011;

    localparam logic [6:0] OPC_ILLEGAL = 7'd0;
    localparam logic [6:0] OPC_UPPER   = 7'd1;
    localparam logic [6:0] OPC_PCUPPER = 7'd2;
    localparam logic [6:0] OPC_JUMP    = 7'd3;
    localparam logic [6:0] OPC_JUMPREG = 7'd4;
    localparam logic [6:0] OPC_STORE0  = 7'd16;
    localparam logic [6:0] OPC_IALU0   = 7'd19;
    localparam logic [6:0] OPC_SHL_I   = 7'd25;
    localparam logic [6:0] OPC_SHRL_I  = 7'd26;
    localparam logic [6:0] OPC_SHRA_I  = 7'd27;
    localparam logic [6:0] OPC_RADD    = 7'd28;
    localparam logic [6:0] OPC_RSUB    = 7'd29;
    localparam logic [6:0] OPC_RSHRA   = 7'd35;
    localparam logic [6:0] OPC_FENCE   = 7'd38;
    localparam logic [6:0] OPC_ENVCALL = 7'd39;
    localparam logic [6:0] OPC_BRKPT   = 7'd40;

endpackage

// File: rtl/pdc_decode.sv
module pdc_decode
    import pdc_pkg::*;
(
    input  logic [31:0] word,
    output rec_t        rec
);
    logic [2:0] f3;
    logic [6:0] f7;
    logic [6:0] op;
    imm_sel_e   sel;
    logic [31:0] imm;

    assign f3 = word[14:12];
    assign f7 = word[31:25];

    always_comb begin
        op  = OPC_ILLEGAL;
        sel = IMM_ZERO;
        case (word[6:0])
            MAJ_LUI:   begin op = OPC_UPPER;   sel = IMM_U; end
            MAJ_AUIPC: begin op = OPC_PCUPPER; sel = IMM_U; end
            MAJ_JAL:   begin op = OPC_JUMP;    sel = IMM_J; end
            MAJ_JALR: if (f3 == 3'd0) begin op = OPC_JUMPREG; sel = IMM_I; end
            MAJ_BRANCH: if (f3[2:1] != 2'b01) begin
                op  = f3[2] ? 7'd3 + {4'd0, f3} : 7'd5 + {4'd0, f3};
                sel = IMM_B;
            end
            MAJ_LOAD: if (f3 != 3'd3 && f3[2:1] != 2'b11) begin
                op  = f3[2] ? 7'd10 + {4'd0, f3} : 7'd11 + {4'd0, f3};
                sel = IMM_I;
            end
            MAJ_STORE: if (f3 < 3'd3) begin
                op  = OPC_STORE0 + {4'd0, f3};
                sel = IMM_S;
            end
            MAJ_OPIMM: begin
                if (f3 == 3'd1) begin
                    if (f7 == 7'h00) begin op = OPC_SHL_I; sel = IMM_SH; end
                end else if (f3 == 3'd5) begin
                    if (f7 == 7'h00)      begin op = OPC_SHRL_I; sel = IMM_SH; end
                    else if (f7 == 7'h20) begin op = OPC_SHRA_I; sel = IMM_SH; end
                end else begin
                    sel = IMM_I;
                    if (f3 == 3'd0)  op = OPC_IALU0;
                    else if (f3[2:1] == 2'b11) op = 7'd17 + {4'd0, f3};
                    else             op = 7'd18 + {4'd0, f3};
                end
            end
            MAJ_OP: begin
                if (f7 == 7'h00) begin
                    if (f3 == 3'd0)       op = OPC_RADD;
                    else if (f3 < 3'd6)   op = 7'd29 + {4'd0, f3};
                    else                  op = 7'd30 + {4'd0, f3};
                end else if (f7 == 7'h20) begin
                    if (f3 == 3'd0)       op = OPC_RSUB;
                    else if (f3 == 3'd5)  op = OPC_RSHRA;
                end
            end
            MAJ_FENCE: if (f3 == 3'd0) begin op = OPC_FENCE; sel = IMM_I; end
            MAJ_SYSTEM: begin
                if (word == 32'h0000_0073)      op = OPC_ENVCALL;
                else if (word == 32'h0010_0073) op = OPC_BRKPT;
            end
            default: op = OPC_ILLEGAL;
        endcase
    end

    always_comb begin
        case (sel)
            IMM_I:   imm = {{20{word[31]}}, word[31:20]};
            IMM_SH:  imm = {27'd0, word[24:20]};
            IMM_S:   imm = {{20{word[31]}}, word[31:25], word[11:7]};
            IMM_B:   imm = {{19{word[31]}}, word[31], word[7], word[30:25], word[11:8], 1'b0};
            IMM_U:   imm = {word[31:12], 12'd0};
            IMM_J:   imm = {{11{word[31]}}, word[31], word[19:12], word[20], word[30:21], 1'b0};
            default: imm = 32'd0;
        endcase
    end

    always_comb begin
        rec.op = op;
        if (op == OPC_ILLEGAL) begin
            rec.rd  = 5'd0;
            rec.rs1 = 5'd0;
            rec.rs2 = 5'd0;
            rec.imm = word;
        end else begin
            rec.rd  = word[11:7];
            rec.rs1 = word[19:15];
            rec.rs2 = word[24:20];
            rec.imm = imm;
        end
    end
endmodule

// File: rtl/pdc_slot_ram.sv
module pdc_slot_ram
    import pdc_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  rec_t          wr_data,
    input  logic [AW-1:0] rd_addr,
    output rec_t          rd_data
);
    localparam int DEPTH = 1 << AW;

    rec_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pdc_cache.sv
module pdc_cache
    import pdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 64,
    parameter int SLOTS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_pc,
    output logic              ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_fault,
    output logic              out_valid,
    output logic [6:0]        out_op,
    output logic [4:0]        out_rd,
    output logic [4:0]        out_rs1,
    output logic [4:0]        out_rs2,
    output logic [31:0]       out_imm,
    output logic              out_fault,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int LINE_W = $clog2(LINES);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BYTE_W = 2;
    localparam int TAG_W  = ADDR_W - SLOT_W - BYTE_W;
    localparam int RAM_AW = LINE_W + SLOT_W;

    typedef struct packed {
        logic                          fetching;
        logic [LINE_W-1:0]             line;
        logic [SLOT_W-1:0]             slot;
        logic [LINES-1:0]              valid;
        logic [LINES-1:0][TAG_W-1:0]   tag;
        logic [LINES-1:0][SLOTS-1:0]   filled;
        logic                          out_valid;
        logic                          out_fault;
        rec_t                          rec;
        logic [ADDR_W-1:0]             fault_addr;
    } state_t;

    state_t q, d;

    logic [LINE_W-1:0] req_line;
    logic [SLOT_W-1:0] req_slot;
    logic [TAG_W-1:0]  req_tag;
    logic [ADDR_W-1:0] fetch_addr;
    logic              accept;
    logic              wr_en;
    rec_t              ram_rd;
    rec_t              dec_rec;
    logic [1:0]        unused_pc_lo;

    assign unused_pc_lo = req_pc[BYTE_W-1:0];
    assign req_slot   = req_pc[SLOT_W+BYTE_W-1:BYTE_W];
    assign req_line   = req_pc[LINE_W+SLOT_W+BYTE_W-1:SLOT_W+BYTE_W];
    assign req_tag    = req_pc[ADDR_W-1:SLOT_W+BYTE_W];
    // Fetch address rebuilt from the stored owner and the slot index.
    assign fetch_addr = {q.tag[q.line], q.slot, {BYTE_W{1'b0}}};
    assign accept     = req_valid && !q.fetching && !flush;

    pdc_decode u_dec (
        .word (mem_rdata),
        .rec  (dec_rec)
    );

    pdc_slot_ram #(.AW(RAM_AW)) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr ({q.line, q.slot}),
        .wr_data (dec_rec),
        .rd_addr ({req_line, req_slot}),
        .rd_data (ram_rd)
    );

    always_comb begin
        d           = q;
        d.out_valid = 1'b0;
        d.out_fault = 1'b0;
        wr_en       = 1'b0;

        if (accept) begin
            d.line = req_line;
            d.slot = req_slot;
            if (q.valid[req_line] && q.tag[req_line] == req_tag) begin
                if (q.filled[req_line][req_slot]) begin
                    d.out_valid = 1'b1;
                    d.rec       = ram_rd;
                end else begin
                    d.fetching = 1'b1;
                end
            end else begin
                d.tag[req_line]    = req_tag;
                d.valid[req_line]  = 1'b1;
                d.filled[req_line] = '0;
                d.fetching         = 1'b1;
            end
        end

        if (q.fetching && mem_rvalid) begin
            d.fetching = 1'b0;
            if (mem_fault) begin
                d.out_fault  = 1'b1;
                d.fault_addr = fetch_addr;
            end else begin
                d.out_valid                = 1'b1;
                d.rec                      = dec_rec;
                d.filled[q.line][q.slot]   = 1'b1;
                wr_en                      = 1'b1;
            end
        end

        if (flush) d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready      = !q.fetching && !flush;
    assign mem_req    = q.fetching;
    assign mem_addr   = fetch_addr;
    assign out_valid  = q.out_valid;
    assign out_op     = q.rec.op;
    assign out_rd     = q.rec.rd;
    assign out_rs1    = q.rec.rs1;
    assign out_rs2    = q.rec.rs2;
    assign out_imm    = q.rec.imm;
    assign out_fault  = q.out_fault;
    assign fault_addr = q.fault_addr;
endmodule

module pdc_cache_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic [ADDR_W-3:0] req_pc_hi,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              mem_fault,
    input logic              out_valid,
    input logic [6:0]        out_op,
    input logic [4:0]        out_rd,
    input logic [4:0]        out_rs1,
    input logic [4:0]        out_rs2,
    input logic              out_fault,
    input logic [ADDR_W-1:0] fault_addr
);
    // R4
    fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_addr[ADDR_W-1:2] == $past(req_pc_hi));

    // R4
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

    // R5
    fill_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rvalid && !mem_fault |=> out_valid && !out_fault && !mem_req);

    // R7
    fault_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_rvalid && mem_fault |=> out_fault && !out_valid && fault_addr == $past(mem_addr));

    // R11
    illegal_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_op == 7'd0 |-> out_rd == 5'd0 && out_rs1 == 5'd0 && out_rs2 == 5'd0);

    // R3
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !mem_req);

    // R8
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush && !mem_req |=> !out_valid && !mem_req);
endmodule

bind pdc_cache pdc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .req_pc_hi  (req_pc[ADDR_W-1:2]),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_fault  (mem_fault),
    .out_valid  (out_valid),
    .out_op     (out_op),
    .out_rd     (out_rd),
    .out_rs1    (out_rs1),
    .out_rs2    (out_rs2),
    .out_fault  (out_fault),
    .fault_addr (fault_addr)
);

// File: tb/pdc_cache_test.sv
module pdc_cache_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [6:0]  op;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [31:0] imm;
    } brec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic        ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic        out_valid;
    logic [6:0]  out_op;
    logic [4:0]  out_rd, out_rs1, out_rs2;
    logic [31:0] out_imm;
    logic        out_fault;
    logic [31:0] fault_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench model of the cache contents.
    bit          mv [64];
    logic [24:0] mt [64];
    bit          mf [64][32];
    brec_t       mrec [64][32];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pdc_cache uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_pc(req_pc),
        .ready(ready), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault), .out_valid(out_valid), .out_op(out_op),
        .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2), .out_imm(out_imm),
        .out_fault(out_fault), .fault_addr(fault_addr)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mix(input logic [31:0] a);
        logic [31:0] r;
        r = a ^ 32'h5bd1_e995;
        r = r * 32'h9E37_79B1;
        r = r ^ (r >> 15);
        r = r * 32'h85EB_CA6B;
        r = r ^ (r >> 13);
        return r;
    endfunction

    // Memory content: a pure function of the word address.
    function automatic logic [31:0] gen_word(input logic [31:0] addr);
        logic [31:0] h, b, w;
        logic [6:0] maj;
        h = mix(addr);
        b = mix(h ^ 32'h1234_5678);
        case (h[3:0])
            4'd0: maj = 7'b0110111;
            4'd1: maj = 7'b0010111;
            4'd2: maj = 7'b1101111;
            4'd3: maj = 7'b1100111;
            4'd4: maj = 7'b1100011;
            4'd5: maj = 7'b0000011;
            4'd6: maj = 7'b0100011;
            4'd7, 4'd8: maj = 7'b0010011;
            4'd9, 4'd10: maj = 7'b0110011;
            4'd11: maj = 7'b0001111;
            default: maj = 7'b1110011;
        endcase
        w = {b[31:7], maj};
        if ((h[3:0] >= 4'd7 && h[3:0] <= 4'd10) && h[4]) w[31:25] = h[5] ? 7'h20 : 7'h00;
        if (h[3:0] == 4'd12) w = 32'h0000_0073;
        if (h[3:0] == 4'd13) w = 32'h0010_0073;
        if (h[3:0] == 4'd15) w = b;
        return w;
    endfunction

    // Reference decode written from R9, R10, R11.
    function automatic brec_t ref_dec(input logic [31:0] w);
        brec_t r;
        logic [2:0] f3;
        logic [6:0] f7;
        logic [31:0] ii, si, bi, ui, ji, sh;
        f3 = w[14:12];
        f7 = w[31:25];
        ii = {{20{w[31]}}, w[31:20]};
        si = {{20{w[31]}}, w[31:25], w[11:7]};
        bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        ui = {w[31:12], 12'd0};
        ji = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        sh = {27'd0, w[24:20]};
        r = '0;
        case (w[6:0])
            7'b0110111: begin r.op = 1; r.imm = ui; end
            7'b0010111: begin r.op = 2; r.imm = ui; end
            7'b1101111: begin r.op = 3; r.imm = ji; end
            7'b1100111: if (f3 == 0) begin r.op = 4; r.imm = ii; end
            7'b1100011: begin
                r.imm = bi;
                case (f3) 0: r.op = 5; 1: r.op = 6; 4: r.op = 7; 5: r.op = 8; 6: r.op = 9; 7: r.op = 10; default: r.op = 0; endcase
            end
            7'b0000011: begin
                r.imm = ii;
                case (f3) 0: r.op = 11; 1: r.op = 12; 2: r.op = 13; 4: r.op = 14; 5: r.op = 15; default: r.op = 0; endcase
            end
            7'b0100011: begin
                r.imm = si;
                case (f3) 0: r.op = 16; 1: r.op = 17; 2: r.op = 18; default: r.op = 0; endcase
            end
            7'b0010011: begin
                r.imm = ii;
                case (f3)
                    0: r.op = 19; 2: r.op = 20; 3: r.op = 21; 4: r.op = 22; 6: r.op = 23; 7: r.op = 24;
                    1: begin r.imm = sh; r.op = (f7 == 7'h00) ? 7'd25 : 7'd0; end
                    default: begin
                        r.imm = sh;
                        r.op = (f7 == 7'h00) ? 7'd26 : (f7 == 7'h20) ? 7'd27 : 7'd0;
                    end
                endcase
            end
            7'b0110011: begin
                if (f7 == 7'h00) begin
                    case (f3) 0: r.op = 28; 1: r.op = 30; 2: r.op = 31; 3: r.op = 32;
                              4: r.op = 33; 5: r.op = 34; 6: r.op = 36; default: r.op = 37; endcase
                end else if (f7 == 7'h20) begin
                    r.op = (f3 == 0) ? 7'd29 : (f3 == 5) ? 7'd35 : 7'd0;
                end
            end
            7'b0001111: if (f3 == 0) begin r.op = 38; r.imm = ii; end
            7'b1110011: begin
                if (w == 32'h0000_0073) r.op = 39;
                else if (w == 32'h0010_0073) r.op = 40;
            end
            default: r.op = 0;
        endcase
        if (r.op == 0) begin
            r.imm = w;
        end else begin
            r.rd = w[11:7]; r.rs1 = w[19:15]; r.rs2 = w[24:20];
        end
        return r;
    endfunction

    function automatic brec_t out_rec();
        return {out_op, out_rd, out_rs1, out_rs2, out_imm};
    endfunction

    // One lookup; all driving and sampling at falling edges.
    task automatic lookup(input logic [31:0] pc, input bit fault, input int lat,
                          input bit use_ovr, input logic [31:0] ovr);
        logic [5:0]  l;
        logic [4:0]  s;
        logic [24:0] t;
        logic [31:0] addr, w;
        bit hit;
        brec_t exp;
        l = pc[12:7]; s = pc[6:2]; t = pc[31:7];
        addr = {t, s, 2'b00};
        while (!ready) @(negedge clk);
        hit = mv[l] && mt[l] == t && mf[l][s];
        req_valid = 1'b1; req_pc = pc;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            check(out_valid == 1'b1 && out_rec() == mrec[l][s], "R3 hit record", 64'(out_rec()), 64'(mrec[l][s]));
            check(mem_req == 1'b0, "R3 hit without memory read", 64'(mem_req), 64'd0);
        end else begin
            if (!(mv[l] && mt[l] == t)) begin
                mv[l] = 1'b1; mt[l] = t;
                for (int k = 0; k < 32; k++) mf[l][k] = 1'b0;
            end
            check(mem_req == 1'b1 && mem_addr == addr, "R4/R6 fetch issued at rebuilt address",
                  {31'd0, mem_req, mem_addr}, {32'd1, addr});
            for (int k = 0; k < lat; k++) begin
                req_valid = 1'b1; req_pc = mix(pc + k);
                @(negedge clk);
                check(ready == 1'b0 && mem_req == 1'b1 && mem_addr == addr, "R12 busy while fetching",
                      {31'd0, ready, mem_addr}, {32'd0, addr});
            end
            w = use_ovr ? ovr : gen_word(addr);
            mem_rvalid = 1'b1; mem_rdata = w; mem_fault = fault;
            req_valid = 1'b1; req_pc = mix(pc ^ 32'hA5A5_0000);
            @(negedge clk);
            mem_rvalid = 1'b0; mem_fault = 1'b0; mem_rdata = mix(w); req_valid = 1'b0;
            if (fault) begin
                check(out_fault == 1'b1 && out_valid == 1'b0 && fault_addr == addr, "R7 fault pulse and address",
                      {30'd0, out_fault, out_valid, fault_addr}, {32'h2, addr});
            end else begin
                exp = ref_dec(w);
                check(out_valid == 1'b1 && out_rec() == exp, "R5/R9/R10/R11 decoded record",
                      64'(out_rec()), 64'(exp));
                mf[l][s] = 1'b1; mrec[l][s] = exp;
            end
            check(mem_req == 1'b0 && ready == 1'b1, "R12 stray request ignored",
                  {62'd0, mem_req, ready}, 64'd1);
        end
    endtask

    task automatic do_flush();
        while (!ready) @(negedge clk);
        flush = 1'b1; req_valid = 1'b1; req_pc = 32'h0000_0100;
        #1;
        check(ready == 1'b0, "R8 ready low during flush", 64'(ready), 64'd0);
        @(negedge clk);
        flush = 1'b0; req_valid = 1'b0;
        check(mem_req == 1'b0 && out_valid == 1'b0, "R8 request in flush cycle not accepted",
              {62'd0, mem_req, out_valid}, 64'd0);
        for (int k = 0; k < 64; k++) mv[k] = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [31:0] words [8];
        void'($urandom(32'd20240611));
        for (int k = 0; k < 64; k++) mv[k] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(ready == 1'b1 && mem_req == 1'b0 && out_valid == 1'b0 && out_fault == 1'b0, "R1 reset state",
              {60'd0, ready, mem_req, out_valid, out_fault}, 64'h8);

        // R4, R5, R3: fill then hit; R2 low bits ignored.
        a = 32'h0000_1A48;
        lookup(a, 0, 2, 0, 0);
        lookup(a, 0, 0, 0, 0);
        lookup(a | 32'h3, 0, 0, 0, 0);
        lookup(a + 4, 0, 1, 0, 0);

        // R7: fault leaves placeholder.
        lookup(32'h0000_1A50, 1, 1, 0, 0);
        lookup(32'h0000_1A50, 0, 0, 0, 0);
        lookup(32'h0000_1A50, 0, 0, 0, 0);

        // R6: conflicting owner on the same line, then the old owner returns.
        lookup(32'h0040_1A48, 0, 0, 0, 0);
        lookup(a, 0, 3, 0, 0);
        lookup(a, 0, 0, 0, 0);

        // R9, R10, R11 directed words.
        words[0] = 32'h0000_0073;
        words[1] = 32'h0010_0073;
        words[2] = 32'h40B5_0533;
        words[3] = 32'h4000_D093;
        words[4] = 32'h0000_2063;
        words[5] = 32'hFFFF_FFFF;
        words[6] = 32'h0200_0033;
        words[7] = 32'hFE52_8EE3;
        for (int k = 0; k < 8; k++) lookup(32'h0004_0000 + 32'(k * 4), 0, k % 3, 1, words[k]);
        for (int k = 0; k < 8; k++) lookup(32'h0004_0000 + 32'(k * 4), 0, 0, 0, 0);

        // R8: flush forces refetch.
        do_flush();
        lookup(32'h0004_0000, 0, 0, 1, words[0]);
        lookup(32'h0004_0000, 0, 0, 0, 0);

        // Random mix.
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] base, pc;
            int sel;
            sel = $urandom % 3;
            base = (sel == 0) ? 32'h0000_0000 : (sel == 1) ? 32'h0000_2000 : 32'h0123_4000;
            pc = base | (32'($urandom % 64) << 7) | (32'($urandom % (($urandom % 4 == 0) ? 32 : 8)) << 2)
                 | 32'($urandom % 4);
            if ($urandom % 80 == 0) do_flush();
            lookup(pc, ($urandom % 16) == 0, $urandom % 4, 0, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule